// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a free-running 48-bit time base that counts ticks of a 32768 Hz clock enable. Because one second is 2^15 ticks, the upper 33 bits of the count hold whole seconds and the lower 15 bits hold the fraction of a second. Software sets the time, sets an alarm and reads both back through a simple half-word bus. The bus has two regions: a time region for the count and the alarm value, and a control region for the interrupt enable and the interrupt status.

A 48-bit alarm value uses the same bit layout as the count. The count may advance on a tick to exactly the alarm value. When that happens, bit 0 of the status register is set and stays set until software writes a one to it. The interrupt output is high while any status bit and its enable bit are both set. Reads return the live count with no snapshot. A read that spans three half-words can therefore be torn, and software must read until two passes agree.

Top module: `etime_alarm_top`

## Requirements
- R1: After reset the count, the alarm value, the interrupt enable and the interrupt status are all zero, and `alarm_irq` is low.
- R2: On each clock edge with `tick_en` high and no count write, the count rises by one. With `tick_en` low and no write, the count holds.
- R3: Count bits 47:15 hold whole seconds. A count loaded with S shifted left by 15 holds S+1 seconds after exactly 32768 ticks. A carry out of bit 15 of one half-word ripples into the next half-word.
- R4: In the time region (`bus_region`=0), the count half-words for bits 15:0, 31:16 and 47:32 sit at byte addresses 0x00, 0x02 and 0x04. The alarm half-words sit at 0x08, 0x0A and 0x0C in the same order. Any other time-region address reads as zero.
- R5: A write to one count half-word replaces only those 16 bits. The new value is visible on the next cycle, and counting continues from it. A write has priority over a tick in the same cycle, and that tick is lost.
- R6: Reads are combinational from the live count. The value read at an address changes as soon as a tick has advanced the count, with no latching between accesses.
- R7: A tick that moves the count to a value equal to the alarm value sets bit 0 of the status register (control region address 0x1E). The bit reads as 0x0001 on the next cycle.
- R8: The status bit stays set while the count moves past the alarm value and while further ticks arrive.
- R9: Writing a one to status bit 0 clears it, and writing a zero leaves it unchanged. If a clearing write and a setting match fall in the same cycle, the bit ends set.
- R10: `alarm_irq` is high exactly when status bit 0 and enable bit 0 are both one. The enable register is at control region address 0x1C, and it reads back as written. With the enable low, the status still sets and can be read.
- R11: A count write that makes the count equal to the alarm value does not set the status bit. Only a tick can cause a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32768 Hz timebase enable, one cycle per tick |
| bus_we | input | 1 | Write strobe for the half-word bus |
| bus_region | input | 1 | 0 selects the time region, 1 selects the control region |
| bus_addr | input | 5 | Byte address within the selected region |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data at `bus_addr` |
| alarm_irq | output | 1 | Masked alarm interrupt |

## Verification
The bench tests the carry from the fraction bits into the seconds bits and the carry across half-word boundaries. A design with the seconds field in the wrong place would show a wrong seconds value after 32768 ticks, and a design that broke the carry between words would leave the middle word unchanged. It drives a count write and a tick in the same cycle, and a clearing write together with a match. A design with either priority reversed would leave an off-by-one count or a cleared flag. A count written to equal the alarm value must not raise the flag, so a design that compares the live count level instead of the tick transition would report a false alarm. The bench also checks that the status stays set after the match has passed and while the interrupt is masked, which catches a flag that only follows the equality.

// File: rtl/etime_pkg.sv
package etime_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic {
    RGN_TIME = 1'b0,
    RGN_CTRL = 1'b1
  } region_e;

  // time region: base byte addresses of the count and alarm half-words
  localparam logic [ADDR_W-1:0] CNT_BASE  = 5'h00;
  localparam logic [ADDR_W-1:0] CMP_BASE  = 5'h08;

  // control region
  localparam logic [ADDR_W-1:0] IRQ_EN_OFS   = 5'h1C;
  localparam logic [ADDR_W-1:0] IRQ_STAT_OFS = 5'h1E;

  // number of interrupt sources; bit 0 is the alarm
  localparam int NUM_SRC   = 1;
  localparam int ALARM_SRC = 0;

endpackage

// File: rtl/etime_counter.sv
module etime_counter #(
  parameter  int CNT_W  = 48,
  parameter  int HW_W   = 16,
  localparam int NUM_HW = CNT_W / HW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NUM_HW-1:0] hw_wr,
  input  logic [HW_W-1:0]   wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_plus,
  output logic              adv
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             any_wr;
  logic             cnt_upd;

  assign any_wr   = |hw_wr;
  assign cnt_plus = cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  assign adv      = tick_en & ~any_wr;
  assign cnt_upd  = tick_en | any_wr;

  always_comb begin
    cnt_nxt = cnt;
    if (any_wr) begin
      for (int i = 0; i < NUM_HW; i++) begin
        if (hw_wr[i]) cnt_nxt[i*HW_W +: HW_W] = wdata;
      end
    end else if (tick_en) begin
      cnt_nxt = cnt_plus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_upd) cnt <= cnt_nxt;
  end

  // R2: a tick without a write advances the count by one
  p_tick_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_wr) |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R2: no tick and no write, no change
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_wr) |=> $stable(cnt));

  generate
    for (genvar g = 0; g < NUM_HW; g++) begin : g_hw_chk
      // R5: a write lands in its own half-word on the next cycle
      p_hw_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_wr[g] |=> (cnt[g*HW_W +: HW_W] == $past(wdata)));
    end
  endgenerate

endmodule

// File: rtl/etime_compare.sv
module etime_compare #(
  parameter  int CNT_W  = 48,
  parameter  int HW_W   = 16,
  localparam int NUM_HW = CNT_W / HW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_wr,
  input  logic [HW_W-1:0]   wdata,
  input  logic              adv,
  input  logic [CNT_W-1:0]  cnt_plus,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit
);

  logic [CNT_W-1:0] cmp_nxt;
  logic             cmp_upd;

  assign cmp_upd = |hw_wr;

  always_comb begin
    cmp_nxt = cmp;
    for (int i = 0; i < NUM_HW; i++) begin
      if (hw_wr[i]) cmp_nxt[i*HW_W +: HW_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp <= '0;
    else if (cmp_upd) cmp <= cmp_nxt;
  end

  // a match is the step of the count onto the alarm value (R7, R11)
  assign hit = adv && (cnt_plus == cmp);

  // R4: the alarm value only changes through its own half-word writes
  p_cmp_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_upd |=> $stable(cmp));

endmodule

// File: rtl/etime_irq.sv
module etime_irq #(
  parameter int NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_hit,
  input  logic               en_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] stat,
  output logic [NUM_SRC-1:0] en,
  output logic               irq
);

  logic [NUM_SRC-1:0] stat_nxt;
  logic               stat_upd;

  assign stat_upd = clr_we | (|src_hit);

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      // a set wins over a clear in the same cycle
      assign stat_nxt[g] = src_hit[g] | (stat[g] & ~(clr_we & wdata[g]));

      // R7: a match raises the flag
      p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_hit[g] |=> stat[g]);
      // R8: the flag holds until a one is written to it
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[g] && !(clr_we && wdata[g])) |=> stat[g]);
      // R9: a clearing write with no match drops the flag
      p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[g] && !src_hit[g]) |=> !stat[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat <= '0;
    else if (stat_upd) stat <= stat_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= wdata;
  end

  assign irq = |(stat & en);

endmodule

// File: rtl/etime_alarm_top.sv
module etime_alarm_top
  import etime_pkg::*;
#(
  parameter  int CNT_W  = 48,
  parameter  int HW_W   = 16,
  localparam int NUM_HW = CNT_W / HW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic              bus_region,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HW_W-1:0]   bus_wdata,
  output logic [HW_W-1:0]   bus_rdata,
  output logic              alarm_irq
);

  logic [NUM_HW-1:0]  cnt_wr;
  logic [NUM_HW-1:0]  cmp_wr;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_plus;
  logic [CNT_W-1:0]   cmp;
  logic               adv;
  logic               hit;
  logic [NUM_SRC-1:0] src_hit;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] en;
  logic               time_sel;
  logic               ctrl_sel;
  logic               en_we;
  logic               clr_we;

  assign time_sel = (bus_region == RGN_TIME);
  assign ctrl_sel = (bus_region == RGN_CTRL);
  assign en_we    = bus_we && ctrl_sel && (bus_addr == IRQ_EN_OFS);
  assign clr_we   = bus_we && ctrl_sel && (bus_addr == IRQ_STAT_OFS);

  generate
    for (genvar g = 0; g < NUM_HW; g++) begin : g_dec
      assign cnt_wr[g] = bus_we && time_sel &&
                         (bus_addr == CNT_BASE + ADDR_W'(2*g));
      assign cmp_wr[g] = bus_we && time_sel &&
                         (bus_addr == CMP_BASE + ADDR_W'(2*g));
    end
  endgenerate

  etime_counter #(.CNT_W(CNT_W), .HW_W(HW_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .hw_wr    (cnt_wr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .cnt_plus (cnt_plus),
    .adv      (adv)
  );

  etime_compare #(.CNT_W(CNT_W), .HW_W(HW_W)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_wr    (cmp_wr),
    .wdata    (bus_wdata),
    .adv      (adv),
    .cnt_plus (cnt_plus),
    .cmp      (cmp),
    .hit      (hit)
  );

  always_comb begin
    src_hit            = '0;
    src_hit[ALARM_SRC] = hit;
  end

  etime_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_hit (src_hit),
    .en_we   (en_we),
    .clr_we  (clr_we),
    .wdata   (bus_wdata[NUM_SRC-1:0]),
    .stat    (stat),
    .en      (en),
    .irq     (alarm_irq)
  );

  // live, unlatched read path
  always_comb begin
    bus_rdata = '0;
    if (time_sel) begin
      for (int i = 0; i < NUM_HW; i++) begin
        if (bus_addr == CNT_BASE + ADDR_W'(2*i)) bus_rdata = cnt[i*HW_W +: HW_W];
        if (bus_addr == CMP_BASE + ADDR_W'(2*i)) bus_rdata = cmp[i*HW_W +: HW_W];
      end
    end else begin
      if (bus_addr == IRQ_EN_OFS)   bus_rdata = {{(HW_W-NUM_SRC){1'b0}}, en};
      if (bus_addr == IRQ_STAT_OFS) bus_rdata = {{(HW_W-NUM_SRC){1'b0}}, stat};
    end
  end

  // R11: a count write cannot produce a match in its cycle
  p_no_write_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_wr) |-> !hit);

  // R10: a rising interrupt needs a set enable
  p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> (en[ALARM_SRC] || $past(en_we)));

endmodule

// File: tb/etime_alarm_top_tb.sv
`timescale 1ns/1ps
module etime_alarm_top_tb;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_we;
  logic        bus_region;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        alarm_irq;

  int checks;
  int failures;
  bit done;

  etime_alarm_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_we     (bus_we),
    .bus_region (bus_region),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .alarm_irq  (alarm_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic rgn, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_region = rgn; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic rgn, input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_region = rgn; bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_count(input logic [47:0] v);
    wr(1'b0, 5'h04, v[47:32]);
    wr(1'b0, 5'h02, v[31:16]);
    wr(1'b0, 5'h00, v[15:0]);
  endtask

  task automatic set_alarm(input logic [47:0] v);
    wr(1'b0, 5'h0C, v[47:32]);
    wr(1'b0, 5'h0A, v[31:16]);
    wr(1'b0, 5'h08, v[15:0]);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 3; i++) begin
      rd(1'b0, 5'(2*i), d);       check("R1 count", d, 0);
      rd(1'b0, 5'(8 + 2*i), d);   check("R1 alarm", d, 0);
    end
    rd(1'b1, 5'h1C, d); check("R1 enable", d, 0);
    rd(1'b1, 5'h1E, d); check("R1 status", d, 0);
    check("R1 irq", alarm_irq, 0);
  endtask

  task automatic t_map();
    logic [15:0] d;
    set_alarm(48'h3333_2222_1111);
    rd(1'b0, 5'h08, d); check("R4 alarm lo", d, 16'h1111);
    rd(1'b0, 5'h0A, d); check("R4 alarm mid", d, 16'h2222);
    rd(1'b0, 5'h0C, d); check("R4 alarm hi", d, 16'h3333);
    rd(1'b0, 5'h06, d); check("R4 hole 0x06", d, 0);
    rd(1'b0, 5'h10, d); check("R4 hole 0x10", d, 0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    ticks(5);
    rd(1'b0, 5'h00, d); check("R2 five ticks", d, 16'h0005);
    repeat (4) @(negedge clk);
    rd(1'b0, 5'h00, d); check("R2 hold no tick", d, 16'h0005);
  endtask

  task automatic t_write();
    logic [15:0] d;
    wr(1'b0, 5'h02, 16'hABCD);
    rd(1'b0, 5'h00, d); check("R5 low untouched", d, 16'h0005);
    rd(1'b0, 5'h02, d); check("R5 mid written", d, 16'hABCD);
    rd(1'b0, 5'h04, d); check("R5 high untouched", d, 16'h0000);
    ticks(1);
    rd(1'b0, 5'h00, d); check("R5 counts on", d, 16'h0006);
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_region = 1'b0; bus_addr = 5'h00; bus_wdata = 16'h0100;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd(1'b0, 5'h00, d); check("R5 write beats tick", d, 16'h0100);
  endtask

  task automatic t_seconds();
    logic [15:0] lo, mid, hi;
    set_count(48'h0000_0000_7FFF);
    ticks(1);
    rd(1'b0, 5'h00, lo); check("R3 fraction to second bit", lo, 16'h8000);
    set_count(48'h0000_0001_FFFF);
    ticks(1);
    rd(1'b0, 5'h00, lo);  check("R3 low wraps", lo, 16'h0000);
    rd(1'b0, 5'h02, mid); check("R3 carry into mid", mid, 16'h0002);
    set_count(48'(5) << 15);
    ticks(32768);
    rd(1'b0, 5'h00, lo); rd(1'b0, 5'h02, mid); rd(1'b0, 5'h04, hi);
    check("R3 seconds after 32768 ticks", {hi, mid, lo} >> 15, 48'd6);
    check("R3 fraction zero", {33'd0, lo[14:0]}, 0);
  endtask

  task automatic t_live();
    logic [15:0] d;
    set_count(48'h0000_0000_0010);
    rd(1'b0, 5'h00, d); check("R6 before tick", d, 16'h0010);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    #0.5 check("R6 live after tick", bus_rdata, 16'h0011);
  endtask

  task automatic t_alarm();
    logic [15:0] d;
    set_count(48'h0000_0000_0100);
    set_alarm(48'h0000_0000_0102);
    wr(1'b1, 5'h1C, 16'h0001);
    rd(1'b1, 5'h1C, d); check("R10 enable readback", d, 16'h0001);
    ticks(1);
    rd(1'b1, 5'h1E, d); check("R7 no flag one short", d, 0);
    ticks(1);
    rd(1'b1, 5'h1E, d); check("R7 flag on match", d, 16'h0001);
    check("R10 irq with enable", alarm_irq, 1);
    ticks(3);
    rd(1'b1, 5'h1E, d); check("R8 flag sticky past match", d, 16'h0001);
    wr(1'b1, 5'h1E, 16'h0000);
    rd(1'b1, 5'h1E, d); check("R9 zero write no effect", d, 16'h0001);
    wr(1'b1, 5'h1C, 16'h0000);
    rd(1'b1, 5'h1E, d); check("R10 status kept when masked", d, 16'h0001);
    check("R10 irq masked", alarm_irq, 0);
    wr(1'b1, 5'h1C, 16'h0001);
    @(negedge clk); check("R10 irq unmasked", alarm_irq, 1);
    wr(1'b1, 5'h1E, 16'h0001);
    rd(1'b1, 5'h1E, d); check("R9 one write clears", d, 0);
    check("R10 irq drops on clear", alarm_irq, 0);
  endtask

  task automatic t_write_no_match();
    logic [15:0] d;
    set_count(48'h0000_0000_0102);
    repeat (3) @(negedge clk);
    rd(1'b1, 5'h1E, d); check("R11 written equal no flag", d, 0);
    check("R11 irq stays low", alarm_irq, 0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    set_count(48'h0000_0000_0101);
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_region = 1'b1; bus_addr = 5'h1E; bus_wdata = 16'h0001;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd(1'b1, 5'h1E, d); check("R9 set beats clear", d, 16'h0001);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0;
    bus_region = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_count();
    t_write();
    t_seconds();
    t_live();
    t_alarm();
    t_write_no_match();
    t_set_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule